// File: doc/BRIEF.md
# I2C Register Slave with Strap-Selected Address

This block is a slave on a two-wire I2C bus. It holds a small bank of 8-bit registers that a bus master can write and read. The 7-bit device address is built from a fixed five-bit prefix and two strap inputs, so up to four of these blocks can share one bus. The block never drives SDA high. It only requests a low level through an open-drain enable, and the pad logic outside the block turns that enable into a pull-down.

A write has three parts: the device address frame with R/W low, one byte that sets the internal register pointer, and one data byte. A read first sets the pointer in the same way. A repeated START follows, then the address frame with R/W high, and the slave returns the selected register MSB first. The pointer survives the repeated START and STOP. Both bus lines pass through a two-stage synchronizer and a persistence filter before START, STOP and clock edges are decoded.

Top module: `i2c_regslave`

## Requirements
- R1: After reset the SDA pull-down enable is low and every register reads back as 0x00.
- R2: The slave acknowledges an address frame, by pulling SDA low through the ninth clock, exactly when bits 7..1 of the first byte after a START equal {5'b00001, dev_sel_i[1:0]}. Bit 0 of that byte is R/W, with 1 meaning read.
- R3: After an address frame that does not match, the slave acknowledges nothing and drives nothing until the next START.
- R4: In a write, the byte after the address frame sets the pointer and the next byte is stored in the selected register. Each of the three bytes is acknowledged.
- R5: The register index is the pointer byte taken modulo NUM_REGS (its low bits). Higher pointer values alias onto the bank.
- R6: The pointer is kept across a repeated START. An address frame with R/W=1 makes the slave shift out the selected register MSB first. It releases SDA for 1 bits and pulls it low for 0 bits, and changes SDA only while SCL is low.
- R7: After a data byte sent by the slave, a master ACK sends the same register again. A master NACK releases SDA and the slave waits for the next START or STOP.
- R8: Bytes after the data byte of a write are not acknowledged and change no register.
- R9: A START at any point, including in the middle of a byte, discards the partial byte and restarts address decoding.
- R10: The bit value is the filtered SDA level in the cycle an SCL rise is accepted. An SDA change accepted in that same cycle counts as data and is never taken as START or STOP.
- R11: An SCL pulse shorter than FILT_CYC clock cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (wired-AND bus) |
| dev_sel_i | input | 2 | Strap pins forming the two low device-address bits |
| sda_oe_o | output | 1 | High requests the pad to pull SDA low |

## Verification
The two line filters have equal latency, so an SDA transition and an SCL rise can be accepted in the same system-clock cycle. The decoder must then take the new SDA level as a data bit and must not report a START or STOP. The bench provokes this by changing SDA in the same clock as every SCL rise of a data byte. The new SDA level is a different value on several bits of the byte. The bench judges the result by reading the register back through a normal pointer write, repeated START and read, and comparing it with the byte it sent. Every address acknowledge in that sequence must also be present.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [3:0] {
    S_IDLE,   // not addressed, wait for START
    S_ADDR,   // receiving device address + R/W
    S_AACK,   // acknowledging the address
    S_PTR,    // receiving register pointer
    S_PACK,   // acknowledging the pointer
    S_WDAT,   // receiving write data
    S_WACK,   // acknowledging write data
    S_RDAT,   // shifting register data out
    S_MACK    // master ACK/NACK slot after read data
  } ctl_state_e;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int FILT_CYC = 3,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);

  logic             meta_q, sync_q;
  logic             flt_q, flt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    flt_d = flt_q;
    cnt_d = cnt_q;
    if (sync_q == flt_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_W'(FILT_CYC - 1)) begin
      flt_d = sync_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE_LVL;
      sync_q <= IDLE_LVL;
      flt_q  <= IDLE_LVL;
      cnt_q  <= '0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      flt_q  <= flt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign line_o = flt_q;

  if (FILT_CYC >= 2) begin : g_chk
    AST_FILT_PERSIST: assert property (@(posedge clk) disable iff (!rst_n) (flt_q != $past(flt_q)) |-> ($past(sync_q) == flt_q && $past(sync_q, 2) == flt_q)); // R11
  end

endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f_i,
  input  logic sda_f_i,
  output logic ev_start_o,
  output logic ev_stop_o,
  output logic ev_rise_o,
  output logic ev_fall_o
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_f_i;
      sda_p_q <= sda_f_i;
    end
  end

  // SDA moving while SCL stays high is a bus condition; SCL moving is a clock edge
  assign ev_start_o = scl_p_q & scl_f_i & sda_p_q & ~sda_f_i;
  assign ev_stop_o  = scl_p_q & scl_f_i & ~sda_p_q & sda_f_i;
  assign ev_rise_o  = ~scl_p_q & scl_f_i;
  assign ev_fall_o  = scl_p_q & ~scl_f_i;

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({ev_start_o, ev_stop_o, ev_rise_o, ev_fall_o})); // R10

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (hit) begin
        mem_q[g] <= wr_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[idx_i];

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n) wr_en_i |=> (rd_data_o == $past(wr_data_i))); // R4

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [4:0] DEV_BASE = 5'b00001,
  localparam int        IDX_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_start_i,
  input  logic             ev_stop_i,
  input  logic             ev_rise_i,
  input  logic             ev_fall_i,
  input  logic             sda_f_i,
  input  logic [1:0]       dev_sel_i,
  input  logic [7:0]       rd_data_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             wr_en_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);
  ctl_state_e       st_q, st_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             rw_q, rw_d;
  logic             ack_q, ack_d;    // second half of an acknowledge slot
  logic             mack_q, mack_d;  // master acknowledged read byte
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             oe_q, oe_d;

  logic [7:0] byte_in;
  logic       last_bit;
  logic [6:0] my_addr;

  assign byte_in  = {sh_q[6:0], sda_f_i};
  assign last_bit = (bit_q == 3'd7);
  assign my_addr  = {DEV_BASE, dev_sel_i};

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    rw_d    = rw_q;
    ack_d   = ack_q;
    mack_d  = mack_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    wr_en_o = 1'b0;
    if (ev_start_i) begin
      st_d  = S_ADDR;
      bit_d = '0;
      oe_d  = 1'b0;
      ack_d = 1'b0;
    end else if (ev_stop_i) begin
      st_d  = S_IDLE;
      oe_d  = 1'b0;
      ack_d = 1'b0;
    end else begin
      case (st_q)
        S_ADDR, S_PTR, S_WDAT: begin
          if (ev_rise_i) begin
            sh_d  = byte_in;
            bit_d = bit_q + 3'd1;
            if (last_bit) begin
              if (st_q == S_ADDR) begin
                if (byte_in[7:1] == my_addr) begin
                  st_d = S_AACK;
                  rw_d = byte_in[0];
                end else begin
                  st_d = S_IDLE;
                end
              end else if (st_q == S_PTR) begin
                ptr_d = byte_in[IDX_W-1:0];
                st_d  = S_PACK;
              end else begin
                wr_en_o = 1'b1;
                st_d    = S_WACK;
              end
            end
          end
        end
        S_AACK, S_PACK, S_WACK: begin
          if (ev_fall_i) begin
            if (!ack_q) begin
              ack_d = 1'b1;
              oe_d  = 1'b1;
            end else begin
              ack_d = 1'b0;
              oe_d  = 1'b0;
              bit_d = '0;
              if (st_q == S_AACK) begin
                if (rw_q) begin
                  st_d = S_RDAT;
                  sh_d = rd_data_i;
                  oe_d = ~rd_data_i[7];
                end else begin
                  st_d = S_PTR;
                end
              end else if (st_q == S_PACK) begin
                st_d = S_WDAT;
              end else begin
                st_d = S_IDLE;
              end
            end
          end
        end
        S_RDAT: begin
          if (ev_rise_i) begin
            sh_d  = {sh_q[6:0], 1'b0};
            bit_d = bit_q + 3'd1;
            if (last_bit) begin
              st_d = S_MACK;
            end
          end else if (ev_fall_i) begin
            oe_d = ~sh_q[7];
          end
        end
        S_MACK: begin
          if (ev_fall_i) begin
            if (!ack_q) begin
              ack_d = 1'b1;
              oe_d  = 1'b0;
            end else begin
              ack_d = 1'b0;
              bit_d = '0;
              if (mack_q) begin
                st_d = S_RDAT;
                sh_d = rd_data_i;
                oe_d = ~rd_data_i[7];
              end else begin
                st_d = S_IDLE;
                oe_d = 1'b0;
              end
            end
          end else if (ev_rise_i && ack_q) begin
            mack_d = ~sda_f_i;
          end
        end
        default: begin
          oe_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
      ack_q  <= 1'b0;
      mack_q <= 1'b0;
      ptr_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rw_q   <= rw_d;
      ack_q  <= ack_d;
      mack_q <= mack_d;
      ptr_q  <= ptr_d;
      oe_q   <= oe_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_data_o = byte_in;
  assign sda_oe_o  = oe_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (st_q == S_IDLE) |-> !oe_q); // R3
  AST_OE_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n) (oe_q != $past(oe_q)) |-> $past(ev_fall_i || ev_start_i || ev_stop_i)); // R6
  AST_PTR_KEEP_START: assert property (@(posedge clk) disable iff (!rst_n) ev_start_i |=> $stable(ptr_q)); // R6

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter int         NUM_REGS = 8,
  parameter int         FILT_CYC = 3,
  parameter logic [4:0] DEV_BASE = 5'b00001,
  localparam int        IDX_W    = $clog2(NUM_REGS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] dev_sel_i,
  output logic       sda_oe_o
);
  localparam int N_LINES = 2;

  logic             rst_meta_q, rst_core_n;
  logic [N_LINES-1:0] raw_lines, flt_lines;
  logic             scl_f, sda_f;
  logic             ev_start, ev_stop, ev_rise, ev_fall;
  logic [IDX_W-1:0] ptr;
  logic             wr_en;
  logic [7:0]       wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  assign raw_lines = {sda_i, scl_i};

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    i2cs_line_filter #(
      .FILT_CYC (FILT_CYC),
      .IDLE_LVL (1'b1)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .line_i (raw_lines[l]),
      .line_o (flt_lines[l])
    );
  end

  assign scl_f = flt_lines[0];
  assign sda_f = flt_lines[1];

  i2cs_bus_events u_evt (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .scl_f_i    (scl_f),
    .sda_f_i    (sda_f),
    .ev_start_o (ev_start),
    .ev_stop_o  (ev_stop),
    .ev_rise_o  (ev_rise),
    .ev_fall_o  (ev_fall)
  );

  i2cs_ctrl #(
    .NUM_REGS (NUM_REGS),
    .DEV_BASE (DEV_BASE)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .ev_start_i (ev_start),
    .ev_stop_i  (ev_stop),
    .ev_rise_i  (ev_rise),
    .ev_fall_i  (ev_fall),
    .sda_f_i    (sda_f),
    .dev_sel_i  (dev_sel_i),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data),
    .sda_oe_o   (sda_oe_o)
  );

  i2cs_regfile #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (8)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .idx_i     (ptr),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data)
  );

endmodule

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb;
  localparam int Q        = 10;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_drv, sda_drv;
  logic       sda_bus;
  logic [1:0] dev_sel;
  logic       sda_oe;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [7:0] exp_mem [8];

  always #5 clk = ~clk;

  assign sda_bus = sda_drv & ~sda_oe;

  i2c_regslave u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_drv),
    .sda_i     (sda_bus),
    .dev_sel_i (dev_sel),
    .sda_oe_o  (sda_oe)
  );

  task automatic tq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tq(Q);
    scl_drv = 1'b1; tq(Q);
    sda_drv = 1'b0; tq(Q);
    scl_drv = 1'b0; tq(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tq(Q);
    scl_drv = 1'b1; tq(Q);
    sda_drv = 1'b1; tq(Q);
  endtask

  task automatic send(input logic [7:0] b, input int nbits, input bit same_edge,
                      input bit glitch, output bit ack);
    ack = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!same_edge) sda_drv = b[i];
      if (glitch) begin
        tq(3); scl_drv = 1'b1; tq(2); scl_drv = 1'b0; tq(Q - 5);
      end else begin
        tq(Q);
      end
      if (same_edge) sda_drv = b[i];
      scl_drv = 1'b1; tq(2 * Q);
      scl_drv = 1'b0; tq(Q);
    end
    if (nbits == 8) begin
      sda_drv = 1'b1; tq(Q);
      scl_drv = 1'b1; tq(Q);
      ack = !sda_bus; tq(Q);
      scl_drv = 1'b0; tq(Q);
    end
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tq(Q);
      scl_drv = 1'b1; tq(Q);
      b[i] = sda_bus; tq(Q);
      scl_drv = 1'b0; tq(Q);
    end
    sda_drv = give_ack ? 1'b0 : 1'b1; tq(Q);
    scl_drv = 1'b1; tq(2 * Q);
    scl_drv = 1'b0; tq(Q);
    sda_drv = 1'b1;
  endtask

  task automatic wr_reg(input logic [6:0] dev, input logic [7:0] ra, input logic [7:0] d,
                        input bit se, input bit gl, output bit a0, output bit a1, output bit a2);
    bus_start();
    send({dev, 1'b0}, 8, 1'b0, 1'b0, a0);
    send(ra, 8, 1'b0, 1'b0, a1);
    send(d, 8, se, gl, a2);
    bus_stop();
  endtask

  task automatic rd_reg(input logic [6:0] dev, input logic [7:0] ra, output logic [7:0] d,
                        output bit a0, output bit a1, output bit a2);
    bus_start();
    send({dev, 1'b0}, 8, 1'b0, 1'b0, a0);
    send(ra, 8, 1'b0, 1'b0, a1);
    bus_start();
    send({dev, 1'b1}, 8, 1'b0, 1'b0, a2);
    recv(1'b0, d);
    bus_stop();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] dev;
    logic [7:0] d, d2;
    bit a0, a1, a2, a3;

    rst_n   = 1'b0;
    scl_drv = 1'b1;
    sda_drv = 1'b1;
    dev_sel = 2'b10;
    dev     = {5'b00001, 2'b10};
    for (int i = 0; i < 8; i++) exp_mem[i] = 8'h00;
    tq(5);
    rst_n = 1'b1;
    tq(10);

    // R1: released bus and zeroed bank after reset
    chk("R1 oe after reset", {7'd0, sda_oe}, 8'h00);
    rd_reg(dev, 8'h05, d, a0, a1, a2);
    chk("R1 reset register value", d, 8'h00);
    chk("R2 read address ack", {7'd0, a2}, 8'h01);

    // R4/R5: fill the bank, odd indices addressed through aliased pointers
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ra;
      logic [7:0] v;
      v  = 8'(i * 37 + 11);
      ra = (i % 2 == 1) ? 8'(i + 8 * (i + 1)) : 8'(i);
      wr_reg(dev, ra, v, 1'b0, 1'b0, a0, a1, a2);
      exp_mem[i] = v;
      chk("R2 write address ack", {7'd0, a0}, 8'h01);
      chk("R4 pointer ack", {7'd0, a1}, 8'h01);
      chk("R4 data ack", {7'd0, a2}, 8'h01);
    end
    for (int i = 0; i < 8; i++) begin
      rd_reg(dev, 8'(i), d, a0, a1, a2);
      chk("R6 readback", d, exp_mem[i]);
      chk("R6 read address ack", {7'd0, a2}, 8'h01);
    end
    rd_reg(dev, 8'hF3, d, a0, a1, a2);
    chk("R5 high pointer alias", d, exp_mem[3]);

    // R7: master ACK repeats the byte, NACK releases
    bus_start();
    send({dev, 1'b0}, 8, 1'b0, 1'b0, a0);
    send(8'h06, 8, 1'b0, 1'b0, a1);
    bus_start();
    send({dev, 1'b1}, 8, 1'b0, 1'b0, a2);
    recv(1'b1, d);
    recv(1'b0, d2);
    chk("R7 first byte", d, exp_mem[6]);
    chk("R7 byte after master ack", d2, exp_mem[6]);
    tq(Q);
    chk("R7 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();

    // R3: sweep every 7-bit address with the strap fixed
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send({7'(a), 1'b0}, 8, 1'b0, 1'b0, a0);
      chk("R2 R3 address sweep ack", {7'd0, a0}, (7'(a) == dev) ? 8'h01 : 8'h00);
      if (7'(a) != dev && (a % 32) == 0) begin
        send(8'h00, 8, 1'b0, 1'b0, a1);
        chk("R3 no ack after mismatch", {7'd0, a1}, 8'h00);
      end
      bus_stop();
    end

    // R2: each strap value moves the address
    for (int s = 0; s < 4; s++) begin
      dev_sel = 2'(s);
      tq(Q);
      bus_start();
      send({5'b00001, 2'(s), 1'b0}, 8, 1'b0, 1'b0, a0);
      bus_stop();
      chk("R2 strap match", {7'd0, a0}, 8'h01);
      bus_start();
      send({5'b00001, 2'(s) ^ 2'b01, 1'b0}, 8, 1'b0, 1'b0, a0);
      bus_stop();
      chk("R2 strap neighbour", {7'd0, a0}, 8'h00);
    end
    dev_sel = 2'b10;
    tq(Q);

    // R8: trailing byte of a write
    bus_start();
    send({dev, 1'b0}, 8, 1'b0, 1'b0, a0);
    send(8'h02, 8, 1'b0, 1'b0, a1);
    send(8'h77, 8, 1'b0, 1'b0, a2);
    send(8'h99, 8, 1'b0, 1'b0, a3);
    bus_stop();
    exp_mem[2] = 8'h77;
    chk("R8 extra byte not acked", {7'd0, a3}, 8'h00);
    rd_reg(dev, 8'h02, d, a0, a1, a2);
    chk("R8 target keeps data byte", d, 8'h77);
    rd_reg(dev, 8'h03, d, a0, a1, a2);
    chk("R8 neighbour unchanged", d, exp_mem[3]);

    // R9: START in the middle of a data byte
    bus_start();
    send({dev, 1'b0}, 8, 1'b0, 1'b0, a0);
    send(8'h04, 8, 1'b0, 1'b0, a1);
    send(8'hC3, 4, 1'b0, 1'b0, a2);
    bus_start();
    send({dev, 1'b0}, 8, 1'b0, 1'b0, a0);
    chk("R9 address acked after abort", {7'd0, a0}, 8'h01);
    send(8'h04, 8, 1'b0, 1'b0, a1);
    bus_stop();
    rd_reg(dev, 8'h04, d, a0, a1, a2);
    chk("R9 partial byte discarded", d, exp_mem[4]);

    // R10: SDA change in the cycle SCL rises
    wr_reg(dev, 8'h06, 8'hA5, 1'b1, 1'b0, a0, a1, a2);
    exp_mem[6] = 8'hA5;
    chk("R10 data ack same-edge", {7'd0, a2}, 8'h01);
    rd_reg(dev, 8'h06, d, a0, a1, a2);
    chk("R10 same-edge value A5", d, 8'hA5);
    wr_reg(dev, 8'h06, 8'h5A, 1'b1, 1'b0, a0, a1, a2);
    exp_mem[6] = 8'h5A;
    rd_reg(dev, 8'h06, d, a0, a1, a2);
    chk("R10 same-edge value 5A", d, 8'h5A);

    // R11: short SCL pulses in every low phase
    wr_reg(dev, 8'h07, 8'h3C, 1'b0, 1'b1, a0, a1, a2);
    exp_mem[7] = 8'h3C;
    chk("R11 data ack with glitches", {7'd0, a2}, 8'h01);
    rd_reg(dev, 8'h07, d, a0, a1, a2);
    chk("R11 glitches ignored", d, 8'h3C);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule